// File: doc/BRIEF.md
# Byte-Wide Serial Peripheral Controller

This block is an 8-bit synchronous serial port that can act as either a clock master or a clock follower. It sits behind a small CPU register bus and exposes one control/status byte and one data byte. As a master, a write to the data byte starts a transfer at once. The block then generates eight SCK pulses from a divided system clock. While it does so, it shifts the buffered byte out and collects the incoming bits.

As a follower, it synchronizes an external SCK (and, when chosen, an active-low select) into its own clock domain. It shifts one bit on each detected pulse. Timing follows SPI mode 0: SCK idles low, incoming data is sampled on the rising edge, and outgoing data advances on the falling edge. The bit order can be set to either direction.

A completion flag doubles as the interrupt request. A collision flag records a data write that arrived while a byte was in flight; that write is discarded.

Top module: `serial_port_unit`

## Requirements
- R1: After reset, the control byte (address 0) and the data byte (address 1) both read 0x00, irq is low, and sck_oe, sdo_oe and cs_oe are all low.
- R2: Control bits 7..2 read back exactly as written. Bit 1 (collision) and bit 0 (done) are cleared by writing 0, and a written 1 leaves them unchanged. Bit 7 is the base-clock select, bits 6:5 the mode, bit 4 enable, bit 3 order, bit 2 select-enable.
- R3: With enable (bit 4) at 0, sck_oe, sdo_oe and cs_oe are low. Clearing enable abandons any transfer and resets the bit counter, so a later transfer still takes a full 8 bits.
- R4: A master (mode bits 6:5 not 11) that is enabled and idle drives sck_o=0 and sdo_o=0 with sck_oe=1 and sdo_oe=1. With bit 2 set it drives cs_o=0 with cs_oe=1; with bit 2 clear, cs_oe=0.
- R5: In master mode, a data write while idle starts 8 SCK pulses. Each SCK half-period lasts D system clocks when bit 7 is 1 and 2*D clocks when it is 0, where D is 1, 4 or 16 for mode 00, 01 or 10. The first rising edge comes one half-period after the write.
- R6: Data follows mode 0. sdi is sampled at each rising SCK edge. sdo presents the first bit from the start of the transfer and advances after each falling edge.
- R7: With bit 3 at 1 the byte moves MSB first; with bit 3 at 0 it moves LSB first. This applies in both directions and in both roles.
- R8: After the 8th falling edge, bit 0 sets and irq follows it. Reading address 1 then returns the received byte, which is latched only at that moment.
- R9: A data write during a transfer is discarded. It sets bit 1 and leaves the outgoing byte unchanged.
- R10: In mode 11 the block never drives SCK or chip-select. It shifts on the external sck_i after a two-flop synchronizer, drives sdo while selected, and completes after 8 pulses.
- R11: In mode 11 with bit 2 set, pulses on sck_i are ignored while cs_i is high. sdo_oe is then low, no completion occurs, and the received byte is unchanged.
- R12: A data write in mode 11 or while disabled only loads the outgoing buffer and starts no transfer. In mode 11, sdo then shows the first bit of the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier for bus_sel |
| bus_addr | input | 1 | 0 selects control, 1 selects data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| irq | output | 1 | Completion interrupt (control bit 0) |
| sck_o | output | 1 | Master serial clock |
| sck_oe | output | 1 | Drive enable for SCK |
| sck_i | input | 1 | External serial clock (follower) |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for serial data out |
| sdi_i | input | 1 | Serial data in |
| cs_o | output | 1 | Active-low select out (master) |
| cs_oe | output | 1 | Drive enable for select |
| cs_i | input | 1 | Active-low select in (follower) |

## Verification
The hardest situations to reach from the ports are a data write that lands in the middle of a running byte, and an enable drop that abandons a partly shifted byte. Both must leave the shift sequence exactly as a model predicts. The bench reaches the first by raising the bus strobe from inside its per-cycle comparison loop, a few half-periods into a slow master transfer. It then keeps comparing SCK and sdo against its model for every remaining cycle. For the second, it disables the block partway through a transfer and then runs a complete transfer, whose exact 8-pulse timing would be broken by a stale bit count.

// File: rtl/sp_pkg.sv
package sp_pkg;
  localparam int SP_DW = 8;

  typedef enum logic [1:0] {
    MODE_FAST  = 2'b00,
    MODE_MID   = 2'b01,
    MODE_SLOW  = 2'b10,
    MODE_SLAVE = 2'b11
  } sp_mode_e;

  // field order equals bit position, MSB first
  typedef struct packed {
    logic     base_full;
    sp_mode_e mode;
    logic     en;
    logic     msb_first;
    logic     cs_en;
    logic     wcol;
    logic     done;
  } sp_ctrl_t;
endpackage

// File: rtl/sp_clkgen.sv
module sp_clkgen #(
  parameter int DIV_MID  = 4,
  parameter int DIV_SLOW = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       base_full,
  input  logic [1:0] mode,
  output logic       tick
);
  localparam int CW = $clog2(2 * DIV_SLOW) + 1;

  logic [CW-1:0] cnt_q, cnt_d, div, half;

  always_comb begin
    case (mode)
      2'b01:   div = CW'(DIV_MID);
      2'b10:   div = CW'(DIV_SLOW);
      default: div = CW'(1);
    endcase
    half = base_full ? div : (div << 1);
  end

  assign tick = run && (cnt_q == half - CW'(1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R5
  div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < half));
endmodule

// File: rtl/sp_sync.sv
module sp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= din;
      else             stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/sp_shifter.sv
module sp_shifter #(
  parameter int W = 8,
  localparam int CNTW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            load,
  input  logic [W-1:0]    load_data,
  input  logic            sample_en,
  input  logic            shift_en,
  input  logic            msb_first,
  input  logic            sdi_bit,
  output logic            sdo_bit,
  output logic [W-1:0]    next_byte,
  output logic            last,
  output logic [CNTW-1:0] cnt_o
);
  logic [W-1:0]    sr_q, sr_d;
  logic            smp_q, smp_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  assign next_byte = msb_first ? {sr_q[W-2:0], smp_q} : {smp_q, sr_q[W-1:1]};
  assign sdo_bit   = msb_first ? sr_q[W-1] : sr_q[0];
  assign last      = (cnt_q == CNTW'(W - 1));
  assign cnt_o     = cnt_q;

  always_comb begin
    sr_d  = sr_q;
    smp_d = smp_q;
    cnt_d = cnt_q;
    if (load)          sr_d = load_data;
    else if (shift_en) sr_d = next_byte;
    if (sample_en)     smp_d = sdi_bit;
    if (clr || load)   cnt_d = '0;
    else if (shift_en) cnt_d = last ? '0 : cnt_q + CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      smp_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      smp_q <= smp_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/serial_port_unit.sv
module serial_port_unit
  import sp_pkg::*;
#(
  parameter int DIV_MID     = 4,
  parameter int DIV_SLOW    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       sck_o,
  output logic       sck_oe,
  input  logic       sck_i,
  output logic       sdo_o,
  output logic       sdo_oe,
  input  logic       sdi_i,
  output logic       cs_o,
  output logic       cs_oe,
  input  logic       cs_i
);
  localparam int DW   = SP_DW;
  localparam int CNTW = $clog2(DW);

  sp_ctrl_t        ctrl_q, ctrl_d;
  logic            run_q, run_d, sck_q, sck_d, sck_prev_q;
  logic [DW-1:0]   rx_q, rx_d, next_byte;
  logic [CNTW-1:0] bit_cnt;
  logic            tick, sdo_bit, last;
  logic            sck_s, cs_s, sdi_s;
  logic            wr_ctrl, wr_data, is_master, is_slave, selected, xfer_busy;
  logic            load, start, m_rise, m_fall, s_rise, s_fall, shift_en, finish, clr;

  // bus decode and role
  assign wr_ctrl   = bus_sel && bus_wr && !bus_addr;
  assign wr_data   = bus_sel && bus_wr &&  bus_addr;
  assign is_master = ctrl_q.en && (ctrl_q.mode != MODE_SLAVE);
  assign is_slave  = ctrl_q.en && (ctrl_q.mode == MODE_SLAVE);
  assign selected  = !ctrl_q.cs_en || !cs_s;
  assign xfer_busy = run_q || (is_slave && (bit_cnt != '0));
  assign load      = wr_data && !xfer_busy;
  assign start     = load && is_master;

  // edge events in both roles
  assign m_rise   = is_master && run_q && tick && !sck_q;
  assign m_fall   = is_master && run_q && tick &&  sck_q;
  assign s_rise   = is_slave && selected &&  sck_s && !sck_prev_q;
  assign s_fall   = is_slave && selected && !sck_s &&  sck_prev_q;
  assign shift_en = m_fall || s_fall;
  assign finish   = shift_en && last;
  assign clr      = !ctrl_q.en || (is_slave && !selected);

  sp_clkgen #(.DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(run_q), .base_full(ctrl_q.base_full),
    .mode(ctrl_q.mode), .tick(tick)
  );

  sp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sck_i, cs_i, sdi_i}), .dout({sck_s, cs_s, sdi_s})
  );

  sp_shifter #(.W(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .load_data(bus_wdata),
    .sample_en(m_rise || s_rise), .shift_en(shift_en), .msb_first(ctrl_q.msb_first),
    .sdi_bit(is_master ? sdi_i : sdi_s), .sdo_bit(sdo_bit), .next_byte(next_byte),
    .last(last), .cnt_o(bit_cnt)
  );

  // next state
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl)
      ctrl_d = sp_ctrl_t'({bus_wdata[7:2], ctrl_q.wcol & bus_wdata[1], ctrl_q.done & bus_wdata[0]});
    if (wr_data && xfer_busy) ctrl_d.wcol = 1'b1;
    if (finish)               ctrl_d.done = 1'b1;

    run_d = run_q;
    if (!is_master)  run_d = 1'b0;
    else if (start)  run_d = 1'b1;
    else if (finish) run_d = 1'b0;

    sck_d = sck_q;
    if (!is_master || !run_q) sck_d = 1'b0;
    else if (tick)            sck_d = !sck_q;

    rx_d = finish ? next_byte : rx_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      run_q      <= 1'b0;
      sck_q      <= 1'b0;
      sck_prev_q <= 1'b0;
      rx_q       <= '0;
    end else begin
      ctrl_q     <= ctrl_d;
      run_q      <= run_d;
      sck_q      <= sck_d;
      sck_prev_q <= sck_s;
      rx_q       <= rx_d;
    end
  end

  // outputs
  assign bus_rdata = bus_addr ? rx_q : ctrl_q;
  assign irq       = ctrl_q.done;
  assign sck_oe    = is_master;
  assign sck_o     = is_master && sck_q;
  assign sdo_oe    = is_master || (is_slave && selected);
  assign sdo_o     = (is_master && run_q) ? sdo_bit : (is_slave ? sdo_bit : 1'b0);
  assign cs_oe     = is_master && ctrl_q.cs_en;
  assign cs_o      = 1'b0;

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |-> (!sck_oe && !sdo_oe && !cs_oe));
  // R3
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.en |=> (bit_cnt == '0));
  // R4
  idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_master && !run_q) |-> (!sck_o && !sdo_o));
  // R8
  done_after_eight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q.done) |-> ($past(bit_cnt) == CNTW'(DW - 1)));
  // R9
  wcol_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_data && xfer_busy) |=> ctrl_q.wcol);
  // R10
  slave_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_slave |-> (!sck_oe && !cs_oe));
endmodule

// File: tb/sim_serial_port_unit.sv
module sim_serial_port_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       irq, sck_o, sck_oe, sck_i, sdo_o, sdo_oe, sdi_i, cs_o, cs_oe, cs_i;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  serial_port_unit u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sck_o(sck_o),
    .sck_oe(sck_oe), .sck_i(sck_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sdi_i(sdi_i),
    .cs_o(cs_o), .cs_oe(cs_oe), .cs_i(cs_i)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int half_of(input bit cks, input logic [1:0] mode);
    int d;
    d = (mode == 2'b00) ? 1 : (mode == 2'b01) ? 4 : 16;
    return cks ? d : 2 * d;
  endfunction

  function automatic bit bit_at(input logic [7:0] v, input int b, input bit msb);
    return msb ? v[7-b] : v[b];
  endfunction

  task automatic bus_write(input bit a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input bit a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // cycle-by-cycle master model: tick count = cycles / half-period
  task automatic master_xfer(input bit cks, input logic [1:0] mode, input bit msb,
                             input bit csen, input logic [7:0] tx, input logic [7:0] rxv,
                             input bit collide);
    logic [7:0] cfg, rd;
    int h, ticks;
    cfg = {cks, mode, 1'b1, msb, csen, 2'b00};
    bus_write(1'b0, cfg);
    bus_write(1'b1, tx);
    h = half_of(cks, mode);
    check_eq("R4 cs_oe during transfer", int'(cs_oe), int'(csen));
    if (csen) check_eq("R4 cs_o low", int'(cs_o), 0);
    for (int k = 0; k <= 16 * h; k++) begin
      if (k > 0) @(negedge clk);
      if (collide && k == 3 * h + 1) begin bus_sel = 1'b0; bus_wr = 1'b0; end
      ticks = k / h;
      if (ticks < 16) begin
        check_eq("R5 sck level", int'(sck_o), ticks % 2);
        check_eq("R6 R7 sdo bit", int'(sdo_o), int'(bit_at(tx, ticks / 2, msb)));
        check_eq("R8 irq low mid-transfer", int'(irq), 0);
        sdi_i = bit_at(rxv, ticks / 2, msb);
        if (collide && k == 3 * h) begin
          bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b1; bus_wdata = ~tx;
        end
      end else begin
        check_eq("R5 sck idle after 8 pulses", int'(sck_o), 0);
        check_eq("R8 irq at completion", int'(irq), 1);
      end
    end
    bus_read(1'b1, rd);
    check_eq("R8 R6 received byte", int'(rd), int'(rxv));
    bus_read(1'b0, rd);
    check_eq("R8 R9 status after transfer", int'(rd), int'({cfg[7:2], collide, 1'b1}));
  endtask

  task automatic slave_xfer(input bit msb, input bit csen, input bit cs_lvl,
                            input logic [7:0] tx, input logic [7:0] rxv,
                            input logic [7:0] exp_rx, input bit exp_done);
    logic [7:0] rd;
    bit sel;
    bus_write(1'b0, {1'b0, 2'b11, 1'b1, msb, csen, 2'b00});
    bus_write(1'b1, tx);
    cs_i = cs_lvl;
    repeat (4) @(negedge clk);
    sel = !csen || !cs_lvl;
    check_eq("R10 slave sck_oe", int'(sck_oe), 0);
    check_eq("R10 slave cs_oe", int'(cs_oe), 0);
    check_eq("R10 R11 slave sdo_oe", int'(sdo_oe), int'(sel));
    for (int b = 0; b < 8; b++) begin
      sdi_i = bit_at(rxv, b, msb);
      repeat (8) @(negedge clk);
      if (sel) check_eq("R10 R7 slave sdo bit", int'(sdo_o), int'(bit_at(tx, b, msb)));
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
      repeat (8) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    check_eq("R10 R11 slave completion", int'(irq), int'(exp_done));
    bus_read(1'b1, rd);
    check_eq("R10 R11 slave received byte", int'(rd), int'(exp_rx));
    cs_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = '0;
    sck_i = 1'b0; sdi_i = 1'b0; cs_i = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    bus_read(1'b0, rd); check_eq("R1 control reset", int'(rd), 0);
    bus_read(1'b1, rd); check_eq("R1 data reset", int'(rd), 0);
    check_eq("R1 irq reset", int'(irq), 0);
    check_eq("R1 enables reset", int'({sck_oe, sdo_oe, cs_oe}), 0);

    // R2: bits 1,0 written as 1 stay 0
    bus_write(1'b0, 8'hAF);
    bus_read(1'b0, rd); check_eq("R2 readback", int'(rd), 8'hAC);
    // R3
    check_eq("R3 disabled enables", int'({sck_oe, sdo_oe, cs_oe}), 0);

    // R4
    bus_write(1'b0, 8'h1C);
    check_eq("R4 idle sck", int'({sck_oe, sck_o}), 2'b10);
    check_eq("R4 idle sdo", int'({sdo_oe, sdo_o}), 2'b10);
    check_eq("R4 idle cs", int'({cs_oe, cs_o}), 2'b10);
    bus_write(1'b0, 8'h18);
    check_eq("R4 cs released", int'(cs_oe), 0);

    // R5 R6 R7 R8 master patterns
    master_xfer(1'b1, 2'b00, 1'b1, 1'b1, 8'hA5, 8'h3C, 1'b0);
    master_xfer(1'b0, 2'b01, 1'b0, 1'b0, 8'h96, 8'hE1, 1'b0);
    // R9 collision mid-transfer
    master_xfer(1'b1, 2'b10, 1'b1, 1'b1, 8'h5A, 8'h81, 1'b1);
    // R2: written 1 keeps flags, written 0 clears
    bus_write(1'b0, 8'hDF);
    bus_read(1'b0, rd); check_eq("R2 flags kept by write 1", int'(rd), 8'hDF);
    bus_write(1'b0, 8'hDC);
    bus_read(1'b0, rd); check_eq("R2 flags cleared by write 0", int'(rd), 8'hDC);
    master_xfer(1'b0, 2'b00, 1'b0, 1'b0, 8'h0F, 8'hF0, 1'b0);

    // R3 abandon mid-transfer, then a full transfer
    bus_write(1'b0, 8'hDC);
    bus_write(1'b1, 8'h77);
    repeat (40) @(negedge clk);
    bus_write(1'b0, 8'hCC);
    check_eq("R3 disabled mid-transfer enables", int'({sck_oe, sdo_oe, cs_oe}), 0);
    repeat (40) @(negedge clk);
    check_eq("R3 no completion after abandon", int'(irq), 0);
    bus_read(1'b1, rd); check_eq("R3 rx unchanged after abandon", int'(rd), 8'hF0);
    master_xfer(1'b1, 2'b01, 1'b1, 1'b0, 8'hC6, 8'h4B, 1'b0);

    // R12 disabled write does not start
    bus_write(1'b0, 8'h08);
    bus_write(1'b1, 8'h55);
    repeat (40) @(negedge clk);
    check_eq("R12 disabled no sck", int'(sck_oe), 0);
    check_eq("R12 disabled no completion", int'(irq), 0);

    // R10 R11 follower patterns
    slave_xfer(1'b1, 1'b0, 1'b1, 8'hC3, 8'h5E, 8'h5E, 1'b1);
    slave_xfer(1'b0, 1'b1, 1'b0, 8'h29, 8'hB4, 8'hB4, 1'b1);
    slave_xfer(1'b1, 1'b1, 1'b1, 8'h6D, 8'h11, 8'hB4, 1'b0);

    // R12 follower write only loads
    bus_write(1'b0, 8'h78);
    bus_write(1'b1, 8'hB1);
    repeat (50) @(negedge clk);
    check_eq("R12 slave no completion", int'(irq), 0);
    check_eq("R12 slave sdo shows new first bit", int'(sdo_o), 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule